// File: doc/BRIEF.md
# Local Scan Port Park Controller

This block sits behind the addressing logic of a multidrop boundary-scan bridge. It drives three local scan rings from one backplane test port. Each ring has its own small state machine. That machine either inserts the ring into the active backplane chain or parks it. A parked ring has its local TAP controllers frozen, because the block holds the ring's mode-select output at a constant level. A ring can be parked in one of four stable controller states: Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR.

Parking and unparking are always synchronised to the bridge's own TAP controller. A park request takes effect when the bridge TAP sits in a stable state, and the ring is parked in that same state. An unpark request takes effect only when the bridge TAP returns to the state the ring was parked in. This keeps the local controllers in step with the backplane controller. A per-port mode mask chooses which rings a request applies to. Requests have no effect while the bridge is not selected.

The serial path has no handshake. It moves one bit per test clock, and the test clock itself paces it. Inserted rings are chained in ascending port order. The bit leaving each inserted ring is retimed by a one-bit pad register on the falling test-clock edge. The last pad drives the backplane data output.

Top module: `lsp_park_ctrl`

## Requirements
- R1: Asynchronous reset (`trst_n` low) puts every port in Parked-TLR without waiting for a clock edge. All `tms_l` bits go to 1, every `tdo_l` bit goes to 1, and `tdo_b` equals `tdi_reg`.
- R2: Bridge TAP state codes on `tap_st` follow the standard encoding: TLR=4'hF, RTI=4'hC, Pause-DR=4'h3, Pause-IR=4'hB, Shift-DR=4'h2. A parked port becomes Unparked at a rising `tck_b` edge only if all of these hold: `sel_en` is 1, `unpark_req` is 1, its `mode_sel` bit is 1, and `tap_st` equals the code of the state the port is parked in.
- R3: An Unparked port becomes parked at a rising `tck_b` edge when `sel_en` is 1, `park_req` is 1, its `mode_sel` bit is 1, and `tap_st` is one of the four stable codes. It is parked in the state that `tap_st` names. A park request has no effect on a port that is already parked. A park request also has no effect while `tap_st` is a non-stable code.
- R4: `tms_l[i]` equals `tms_b` while port i is Unparked. It is held at 1 in Parked-TLR and at 0 in Parked-RTI, Parked-Pause-DR and Parked-Pause-IR.
- R5: Ports change state independently. A port whose `mode_sel` bit is 0 keeps its state whatever the requests are.
- R6: While `sel_en` is 0, no port changes state.
- R7: Unparked ports are chained in ascending index. The first inserted port's `tdo_l` is `tdi_reg`. Each later inserted port's `tdo_l` is the previous inserted port's pad bit. `tdo_b` is the last inserted port's pad bit, or `tdi_reg` when no port is inserted.
- R8: The pad bit of each port samples `tdi_l[i]` on the falling edge of `tck_b`. A rising edge does not change it.
- R9: `tck_l[i]` follows `tck_b`. `loc_drv_en` is the inverse of `oe_n`: 1 enables the local TCK, TMS and TDO drivers, and 0 requests high impedance.
- R10: The `tdo_l` output of a port that is not inserted is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_b | input | 1 | Backplane test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms_b | input | 1 | Backplane test mode select |
| tdi_reg | input | 1 | Serial output of the selected bridge register |
| tap_st | input | 4 | Current bridge TAP state code |
| sel_en | input | 1 | Bridge selected by the addressing logic |
| park_req | input | 1 | Park instruction decoded and active |
| unpark_req | input | 1 | Unpark instruction decoded and active |
| mode_sel | input | 3 | Per-port target mask from the mode register |
| oe_n | input | 1 | Local port output enable, active low |
| tdi_l | input | 3 | Serial data returning from each local ring |
| tck_l | output | 3 | Local test clock per port |
| tms_l | output | 3 | Local test mode select per port |
| tdo_l | output | 3 | Serial data sent into each local ring |
| loc_drv_en | output | 1 | Enable for the local tri-state drivers |
| tdo_b | output | 1 | Serial data toward the backplane output |

## Verification
A port stuck in the wrong parked state shows up on its `tms_l` bit within the same clock period. The bench can see this because it drives `tms_b` to the level that separates the candidate states. A port that is wrongly inserted or left out changes the `tdo_l` routing and `tdo_b` as soon as its state changes. The pad register only reveals a wrong sampling edge half a period later, so the bench drives new `tdi_l` values between the two edges. It then samples once after the rising edge and once after the falling edge.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  localparam logic [3:0] TAP_TLR = 4'hF;
  localparam logic [3:0] TAP_RTI = 4'hC;
  localparam logic [3:0] TAP_PDR = 4'h3;
  localparam logic [3:0] TAP_PIR = 4'hB;

  typedef enum logic [2:0] {
    PK_TLR   = 3'd0,
    PK_RTI   = 3'd1,
    PK_PDR   = 3'd2,
    PK_PIR   = 3'd3,
    UNPARKED = 3'd4
  } port_st_e;

  // TAP code a parked port must see before it may rejoin the chain
  function automatic logic [3:0] rejoin_code(input port_st_e s);
    case (s)
      PK_RTI:  return TAP_RTI;
      PK_PDR:  return TAP_PDR;
      PK_PIR:  return TAP_PIR;
      default: return TAP_TLR;
    endcase
  endfunction

  // parked state matching a stable TAP code; UNPARKED means "not stable"
  function automatic port_st_e hold_state(input logic [3:0] t);
    case (t)
      TAP_TLR: return PK_TLR;
      TAP_RTI: return PK_RTI;
      TAP_PDR: return PK_PDR;
      TAP_PIR: return PK_PIR;
      default: return UNPARKED;
    endcase
  endfunction

endpackage

// File: rtl/lsp_port_fsm.sv
module lsp_port_fsm
  import lsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_en,
  input  logic       park_req,
  input  logic       unpark_req,
  input  logic       target,
  input  logic [3:0] tap_st,
  input  logic       tms_b,
  output logic       inserted,
  output logic       tms_l
);

  port_st_e st, st_nxt;
  port_st_e park_to;

  assign park_to = hold_state(tap_st);

  always_comb begin
    st_nxt = st;
    if (sel_en && target) begin
      if (st == UNPARKED) begin
        if (park_req && park_to != UNPARKED) st_nxt = park_to;
      end else if (unpark_req && tap_st == rejoin_code(st)) begin
        st_nxt = UNPARKED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= PK_TLR;
    else        st <= st_nxt;
  end

  assign inserted = (st == UNPARKED);

  always_comb begin
    case (st)
      UNPARKED: tms_l = tms_b;
      PK_TLR:   tms_l = 1'b1;
      default:  tms_l = 1'b0;
    endcase
  end

  AST_UNPARK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inserted) |-> ($past(sel_en) && $past(unpark_req) && $past(target)
                         && $past(tap_st) == rejoin_code($past(st)))); // R2

  AST_PARK_IN_TAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inserted) |-> ($past(park_req) && st == hold_state($past(tap_st)))); // R3

  AST_FROZEN_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en || !target) |=> $stable(st)); // R6

  AST_PARKED_TMS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!inserted && $stable(st)) |-> $stable(tms_l)); // R4

endmodule

// File: rtl/lsp_pad.sv
module lsp_pad (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

endmodule

// File: rtl/lsp_stitch.sv
module lsp_stitch #(
  parameter int N_PORTS = 3
) (
  input  logic               tdi_reg,
  input  logic [N_PORTS-1:0] inserted,
  input  logic [N_PORTS-1:0] pad_q,
  output logic [N_PORTS-1:0] tdo_l,
  output logic               tdo_b
);

  logic [N_PORTS:0] hop;

  assign hop[0] = tdi_reg;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_hop
    assign tdo_l[i]  = inserted[i] ? hop[i]   : 1'b1;
    assign hop[i+1]  = inserted[i] ? pad_q[i] : hop[i];
  end

  assign tdo_b = hop[N_PORTS];

  always_comb begin
    if (inserted == '0) AST_BYPASS_PATH: assert (tdo_b == tdi_reg); // R7
  end

endmodule

// File: rtl/lsp_park_ctrl.sv
module lsp_park_ctrl #(
  parameter int N_PORTS = 3
) (
  input  logic               tck_b,
  input  logic               trst_n,
  input  logic               tms_b,
  input  logic               tdi_reg,
  input  logic [3:0]         tap_st,
  input  logic               sel_en,
  input  logic               park_req,
  input  logic               unpark_req,
  input  logic [N_PORTS-1:0] mode_sel,
  input  logic               oe_n,
  input  logic [N_PORTS-1:0] tdi_l,
  output logic [N_PORTS-1:0] tck_l,
  output logic [N_PORTS-1:0] tms_l,
  output logic [N_PORTS-1:0] tdo_l,
  output logic               loc_drv_en,
  output logic               tdo_b
);

  logic [N_PORTS-1:0] inserted;
  logic [N_PORTS-1:0] pad_q;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    lsp_port_fsm u_fsm (
      .clk        (tck_b),
      .rst_n      (trst_n),
      .sel_en     (sel_en),
      .park_req   (park_req),
      .unpark_req (unpark_req),
      .target     (mode_sel[i]),
      .tap_st     (tap_st),
      .tms_b      (tms_b),
      .inserted   (inserted[i]),
      .tms_l      (tms_l[i])
    );

    lsp_pad u_pad (
      .clk   (tck_b),
      .rst_n (trst_n),
      .d     (tdi_l[i]),
      .q     (pad_q[i])
    );

    assign tck_l[i] = tck_b;
  end

  lsp_stitch #(.N_PORTS(N_PORTS)) u_stitch (
    .tdi_reg  (tdi_reg),
    .inserted (inserted),
    .pad_q    (pad_q),
    .tdo_l    (tdo_l),
    .tdo_b    (tdo_b)
  );

  assign loc_drv_en = ~oe_n;

  AST_RESET_ALL_TLR: assert property (@(posedge tck_b)
    !trst_n |-> (tms_l == '1 && tdo_l == '1)); // R1

endmodule

// File: tb/tb_lsp_park_ctrl.sv
module tb_lsp_park_ctrl;

  localparam int PERIOD = 20;
  localparam int Q = PERIOD / 4;

  logic       tck_b = 1'b0;
  logic       trst_n, tms_b, tdi_reg, sel_en, park_req, unpark_req, oe_n;
  logic [3:0] tap_st;
  logic [2:0] mode_sel, tdi_l;
  logic [2:0] tck_l, tms_l, tdo_l;
  logic       loc_drv_en, tdo_b;

  int n_chk = 0;
  int n_bad = 0;

  lsp_park_ctrl #(.N_PORTS(3)) dut (
    .tck_b(tck_b), .trst_n(trst_n), .tms_b(tms_b), .tdi_reg(tdi_reg),
    .tap_st(tap_st), .sel_en(sel_en), .park_req(park_req),
    .unpark_req(unpark_req), .mode_sel(mode_sel), .oe_n(oe_n),
    .tdi_l(tdi_l), .tck_l(tck_l), .tms_l(tms_l), .tdo_l(tdo_l),
    .loc_drv_en(loc_drv_en), .tdo_b(tdo_b)
  );

  always #(PERIOD/2) tck_b = ~tck_b;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // row: sel, park, unpark, mode[2:0], tap[3:0], tms_b, expected tms_l[2:0]
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,3'b001,4'hF,1'b0,3'b110}, // R2 p0 unparks from TLR
    {1'b1,1'b1,1'b0,3'b001,4'hC,1'b1,3'b110}, // R3 p0 parks in RTI
    {1'b0,1'b0,1'b1,3'b111,4'hF,1'b0,3'b110}, // R6 unselected
    {1'b1,1'b0,1'b1,3'b111,4'hF,1'b0,3'b000}, // R2 p1,p2 unpark; p0 waits
    {1'b1,1'b0,1'b1,3'b001,4'hC,1'b1,3'b111}, // R2 p0 unparks at RTI
    {1'b1,1'b1,1'b0,3'b010,4'h3,1'b1,3'b101}, // R5 p1 parks Pause-DR
    {1'b1,1'b1,1'b0,3'b100,4'hB,1'b1,3'b001}, // R4 p2 parks Pause-IR
    {1'b1,1'b0,1'b1,3'b110,4'hB,1'b1,3'b101}, // R2 only p2 matches
    {1'b1,1'b0,1'b1,3'b010,4'h3,1'b0,3'b000}, // R2 p1 unparks at Pause-DR
    {1'b1,1'b1,1'b0,3'b111,4'h2,1'b1,3'b111}, // R3 non-stable ignored
    {1'b1,1'b1,1'b0,3'b111,4'hF,1'b0,3'b111}, // R3 all park in TLR
    {1'b1,1'b1,1'b0,3'b111,4'hC,1'b0,3'b111}, // R3 re-park ignored
    {1'b1,1'b0,1'b1,3'b101,4'hF,1'b0,3'b010}  // R5 p0,p2 unpark
  };

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms_b = 1'b0; tdi_reg = 1'b0; sel_en = 1'b0;
    park_req = 1'b0; unpark_req = 1'b0; oe_n = 1'b0;
    tap_st = 4'hF; mode_sel = 3'b000; tdi_l = 3'b000;

    #3;
    chk("R1 tms_l", {5'b0, tms_l}, 8'h07);
    chk("R1 tdo_l", {5'b0, tdo_l}, 8'h07);
    chk("R1 tdo_b low", {7'b0, tdo_b}, 8'h00);
    tdi_reg = 1'b1; #1;
    chk("R1 tdo_b high", {7'b0, tdo_b}, 8'h01);
    tdi_reg = 1'b0;

    @(posedge tck_b); @(posedge tck_b); #Q;
    trst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      {sel_en, park_req, unpark_req, mode_sel, tap_st, tms_b} = VEC[k][13:3];
      @(posedge tck_b); #Q;
      chk($sformatf("R2/R3/R4 vec%0d", k), {5'b0, tms_l}, {5'b0, VEC[k][2:0]});
    end

    // p0 and p2 inserted, p1 parked TLR
    sel_en = 1'b0;
    tms_b = 1'b1; #1;
    chk("R4 unparked follows tms_b", {5'b0, tms_l}, 8'h07);
    tms_b = 1'b0;
    tdi_reg = 1'b0; tdi_l = 3'b001;
    #(PERIOD/2); // past falling edge
    chk("R7 tdo_l first gets tdi_reg", {7'b0, tdo_l[0]}, 8'h00);
    chk("R10 bypassed port tdo_l high", {7'b0, tdo_l[1]}, 8'h01);
    chk("R7 p2 fed by pad0", {7'b0, tdo_l[2]}, 8'h01);
    chk("R7 tdo_b from pad2", {7'b0, tdo_b}, 8'h00);
    tdi_l = 3'b100;
    #(PERIOD/2); // past rising edge only
    chk("R8 rising edge no sample p2", {7'b0, tdo_l[2]}, 8'h01);
    chk("R8 rising edge no sample b", {7'b0, tdo_b}, 8'h00);
    #(PERIOD/2); // past falling edge
    chk("R8 falling sample pad0", {7'b0, tdo_l[2]}, 8'h00);
    chk("R8 falling sample pad2", {7'b0, tdo_b}, 8'h01);
    tdi_reg = 1'b1; #1;
    chk("R7 tdi_reg into first port", {7'b0, tdo_l[0]}, 8'h01);

    // clock and driver enable
    @(posedge tck_b); #Q;
    chk("R9 tck_l high", {5'b0, tck_l}, 8'h07);
    oe_n = 1'b1; #1;
    chk("R9 drivers off", {7'b0, loc_drv_en}, 8'h00);
    #(PERIOD/2);
    chk("R9 tck_l low", {5'b0, tck_l}, 8'h00);
    oe_n = 1'b0; #1;
    chk("R9 drivers on", {7'b0, loc_drv_en}, 8'h01);

    // asynchronous reset mid-run
    trst_n = 1'b0; #1;
    chk("R1 async tms_l", {5'b0, tms_l}, 8'h07);
    chk("R1 async tdo_b", {7'b0, tdo_b}, {7'b0, tdi_reg});

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule